// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This unit inspects one 64-bit IEEE 754 double-precision operand per clock cycle. It reports the operand's class as a one-hot vector (zero, subnormal, normal, infinity, NaN). It also says whether the operand is a NaN and whether that NaN is signaling. A runtime convention bit chooses how the top fraction bit is read. With the bit set (the 2008 convention), a clear top fraction bit marks a signaling NaN. With the bit clear (the legacy convention), a set top fraction bit marks a signaling NaN.

When the caller asserts a quiet request together with a signaling NaN, the unit returns the quieted bit pattern. It also pulses an invalid-operation flag for one cycle. Under the 2008 convention, quieting sets the top fraction bit. Under the legacy convention, quieting clears that bit. If clearing it would leave an all-zero fraction, which would turn the value into an infinity, the next lower fraction bit is set instead so the value stays a NaN.

All outputs are registered, so they appear one clock after the operand is presented. No arithmetic, rounding, trap enables or sticky flags are included.

Top module: `dp_nan_unit`

## Requirements
- R1: One cycle after an operand is presented, `classOut` is one-hot with bit 4 = NaN, bit 3 = infinity, bit 2 = normal, bit 1 = subnormal, bit 0 = zero. Exponent field is bits 62:52, fraction is bits 51:0, sign is bit 63.
- R2: `isNan` is 1 exactly when the exponent field is all ones (0x7FF) and the fraction is nonzero. An all-ones exponent with a zero fraction classes as infinity.
- R3: `isSignaling` is 1 exactly when the operand is a NaN and (`mode2008` XOR fraction bit 51) is 1.
- R4: With `mode2008`=1, a quiet request on a signaling NaN returns the operand with fraction bit 51 set.
- R5: With `mode2008`=0, a quiet request on a signaling NaN returns the operand with fraction bit 51 cleared. If the fraction then becomes zero, fraction bit 50 is set.
- R6: Quieting never changes the sign bit or the exponent field.
- R7: `invalidPulse` is 1 for the single cycle after each quiet request on a signaling NaN, and 0 in every other cycle.
- R8: Without a quiet request, `result` equals the operand presented one cycle earlier.
- R9: While `rstN` is low, the outputs read as for a +0 operand: `result`=0, `classOut`=5'b00001, and `isNan`, `isSignaling` and `invalidPulse` are all 0.
- R10: `quietReq` may be asserted only with a signaling NaN operand under the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| operand | input | 64 | Double-precision operand |
| mode2008 | input | 1 | 1 = 2008 NaN convention, 0 = legacy convention |
| quietReq | input | 1 | Request to quiet the operand (signaling NaN only) |
| result | output | 64 | Quieted pattern, or the operand passed through |
| classOut | output | 5 | One-hot operand class |
| isNan | output | 1 | Operand is a NaN |
| isSignaling | output | 1 | Operand is a signaling NaN under the current mode |
| invalidPulse | output | 1 | Invalid-operation pulse from a quiet |

## Verification
The checker assumes the caller never raises `quietReq` unless the operand is a signaling NaN under the mode bit presented in the same cycle. It treats any other request as a protocol violation. The stimulus table pairs every quiet request with a NaN whose bit 51 disagrees with the convention in force. Quiet NaNs, infinities and finite values are presented only with the request held low. Quiet requests are checked under both conventions, including the legacy case whose fraction would otherwise clear to zero.

// File: rtl/dp_nan_pkg.sv
package dp_nan_pkg;
  localparam int CLS_W    = 5;
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_NAN  = 4;

  typedef struct packed {
    logic quietSel;
    logic raiseInv;
  } nanCtrl_t;
endpackage

// File: rtl/dp_nan_classify.sv
module dp_nan_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]             expField,
  input  logic [FRAC_W-1:0]            fracField,
  input  logic                         mode2008,
  output logic [dp_nan_pkg::CLS_W-1:0] classVec,
  output logic                         nanNow,
  output logic                         sigNow
);
  import dp_nan_pkg::*;
  localparam int QB = FRAC_W - 1;

  logic expOnes, expZero, fracZero;

  always_comb begin
    expOnes  = &expField;
    expZero  = ~|expField;
    fracZero = ~|fracField;
    classVec = '0;
    classVec[CLS_NAN]  = expOnes & ~fracZero;
    classVec[CLS_INF]  = expOnes & fracZero;
    classVec[CLS_NORM] = ~expOnes & ~expZero;
    classVec[CLS_SUB]  = expZero & ~fracZero;
    classVec[CLS_ZERO] = expZero & fracZero;
    nanNow = classVec[CLS_NAN];
    sigNow = nanNow & (mode2008 ^ fracField[QB]);
  end
endmodule

// File: rtl/dp_nan_datapath.sv
module dp_nan_datapath #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [EXP_W+FRAC_W:0]                 operand,
  input  logic                                  mode2008,
  input  dp_nan_pkg::nanCtrl_t                  ctrl,
  output logic                                  sigNow,
  output logic [EXP_W+FRAC_W:0]                 result,
  output logic [dp_nan_pkg::CLS_W-1:0]          classOut,
  output logic                                  isNan,
  output logic                                  isSignaling
);
  import dp_nan_pkg::*;
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int QB = FRAC_W - 1;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField, fracQuiet, fracCleared;
  logic [CLS_W-1:0]  classNow;
  logic              nanNow;
  logic [W-1:0]      nextResult;

  assign expField  = operand[W-2 -: EXP_W];
  assign fracField = operand[FRAC_W-1:0];

  dp_nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uClass (
    .expField (expField),
    .fracField(fracField),
    .mode2008 (mode2008),
    .classVec (classNow),
    .nanNow   (nanNow),
    .sigNow   (sigNow)
  );

  always_comb begin
    fracCleared = fracField;
    fracCleared[QB] = 1'b0;
    if (mode2008) begin
      fracQuiet = fracField;
      fracQuiet[QB] = 1'b1;
    end else begin
      fracQuiet = fracCleared;
      if (fracCleared == '0) fracQuiet[QB-1] = 1'b1;
    end
    nextResult = ctrl.quietSel ? {operand[W-1:FRAC_W], fracQuiet} : operand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      classOut    <= CLS_W'(1) << CLS_ZERO;
      isNan       <= 1'b0;
      isSignaling <= 1'b0;
    end else begin
      result      <= nextResult;
      classOut    <= classNow;
      isNan       <= nanNow;
      isSignaling <= sigNow;
    end
  end
endmodule

// File: rtl/dp_nan_ctrl.sv
module dp_nan_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 quietReq,
  input  logic                 sigNow,
  output dp_nan_pkg::nanCtrl_t ctrl,
  output logic                 invalidPulse
);
  always_comb begin
    ctrl.quietSel = quietReq & sigNow;
    ctrl.raiseInv = quietReq & sigNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) invalidPulse <= 1'b0;
    else       invalidPulse <= ctrl.raiseInv;
  end
endmodule

// File: rtl/dp_nan_unit.sv
module dp_nan_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [EXP_W+FRAC_W:0]    operand,
  input  logic                     mode2008,
  input  logic                     quietReq,
  output logic [EXP_W+FRAC_W:0]    result,
  output logic [4:0]               classOut,
  output logic                     isNan,
  output logic                     isSignaling,
  output logic                     invalidPulse
);
  dp_nan_pkg::nanCtrl_t ctrl;
  logic sigNow;

  dp_nan_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .quietReq(quietReq), .sigNow(sigNow),
    .ctrl(ctrl), .invalidPulse(invalidPulse)
  );

  dp_nan_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uData (
    .clk(clk), .rstN(rstN), .operand(operand), .mode2008(mode2008),
    .ctrl(ctrl), .sigNow(sigNow), .result(result), .classOut(classOut),
    .isNan(isNan), .isSignaling(isSignaling)
  );
endmodule

// File: rtl/dp_nan_unit_chk.sv
module dp_nan_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [EXP_W+FRAC_W:0] operand,
  input logic                  mode2008,
  input logic                  quietReq,
  input logic [EXP_W+FRAC_W:0] result,
  input logic [4:0]            classOut,
  input logic                  isNan,
  input logic                  isSignaling,
  input logic                  invalidPulse
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int QB = FRAC_W - 1;

  // R1
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(classOut));

  // R2
  nan_class_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    isNan == classOut[4]);

  // R3
  sig_implies_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSignaling |-> isNan);

  // R4
  quiet2008_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietReq && mode2008) |=> result[QB]);

  // R5
  quietlegacy_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietReq && !mode2008) |=> (!result[QB] && result[FRAC_W-1:0] != '0));

  // R6
  quiet_keeps_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietReq |=> result[W-1:FRAC_W] == $past(operand[W-1:FRAC_W]));

  // R7
  invalid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidPulse |-> $past(quietReq));

  // R7
  invalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietReq |=> invalidPulse);

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !quietReq |=> result == $past(operand));

  // R10
  quiet_protocol_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietReq |-> ((&operand[W-2:FRAC_W]) && (operand[FRAC_W-1:0] != '0)
                  && (mode2008 ^ operand[QB])));
endmodule

bind dp_nan_unit dp_nan_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uChk (
  .clk(clk), .rstN(rstN), .operand(operand), .mode2008(mode2008),
  .quietReq(quietReq), .result(result), .classOut(classOut), .isNan(isNan),
  .isSignaling(isSignaling), .invalidPulse(invalidPulse)
);

// File: tb/sim_dp_nan_unit.sv
module sim_dp_nan_unit;
  localparam int N = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] operand = '0;
  logic        mode2008 = 1'b0;
  logic        quietReq = 1'b0;
  logic [63:0] result;
  logic [4:0]  classOut;
  logic        isNan, isSignaling, invalidPulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dp_nan_unit u0 (
    .clk(clk), .rstN(rstN), .operand(operand), .mode2008(mode2008),
    .quietReq(quietReq), .result(result), .classOut(classOut), .isNan(isNan),
    .isSignaling(isSignaling), .invalidPulse(invalidPulse)
  );

  localparam logic [63:0] opTab [N] = '{
    64'h0000000000000000, 64'h8000000000000001, 64'h3FF0000000000000,
    64'hFFF0000000000000, 64'h7FF0000000000001, 64'h7FF0000000000001,
    64'h7FF8000000000000, 64'hFFFC000000000000, 64'h7FF8000000000000,
    64'hFFF0000000000001, 64'h7FEFFFFFFFFFFFFF, 64'h000FFFFFFFFFFFFF,
    64'h7FFFFFFFFFFFFFFF, 64'h7FF8000000000000 };
  localparam logic modeTab  [N] = '{0,0,0,0,0,1,0,0,1,1,0,0,0,1};
  localparam logic quietTab [N] = '{0,0,0,0,0,1,1,1,0,1,0,0,1,0};
  localparam logic [63:0] resTab [N] = '{
    64'h0000000000000000, 64'h8000000000000001, 64'h3FF0000000000000,
    64'hFFF0000000000000, 64'h7FF0000000000001, 64'h7FF8000000000001,
    64'h7FF4000000000000, 64'hFFF4000000000000, 64'h7FF8000000000000,
    64'hFFF8000000000001, 64'h7FEFFFFFFFFFFFFF, 64'h000FFFFFFFFFFFFF,
    64'h7FF7FFFFFFFFFFFF, 64'h7FF8000000000000 };
  localparam logic [4:0] clsTab [N] = '{
    5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000, 5'b10000, 5'b10000,
    5'b10000, 5'b10000, 5'b10000, 5'b00100, 5'b00010, 5'b10000, 5'b10000 };
  localparam logic snanTab [N] = '{0,0,0,0,0,1,1,1,0,1,0,0,1,0};
  string resTag [N] = '{"R8","R8","R8","R8","R8","R4 R6","R5 R6","R5 R6",
                        "R8","R4 R6","R8","R8","R5 R6","R8"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] op, input logic m, input logic q);
    operand  = op;
    mode2008 = m;
    quietReq = q;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state reads as +0
    chk("R9 result", result, 64'h0);
    chk("R9 class", {59'h0, classOut}, 64'h1);
    chk("R9 flags", {61'h0, isNan, isSignaling, invalidPulse}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < N; i++) begin
      drive(opTab[i], modeTab[i], quietTab[i]);
      chk($sformatf("R1 class v%0d", i), {59'h0, classOut}, {59'h0, clsTab[i]});
      chk($sformatf("R2 isNan v%0d", i), {63'h0, isNan}, {63'h0, clsTab[i][4]});
      chk($sformatf("R3 isSignaling v%0d", i), {63'h0, isSignaling}, {63'h0, snanTab[i]});
      chk($sformatf("%s result v%0d", resTag[i], i), result, resTab[i]);
      chk($sformatf("R7 invalid v%0d", i), {63'h0, invalidPulse}, {63'h0, quietTab[i]});
    end

    // R7: pulse lasts one cycle after a single quiet
    drive(64'h7FF0000000000005, 1'b1, 1'b1);
    chk("R7 pulse on", {63'h0, invalidPulse}, 64'h1);
    chk("R4 r4_odd result", result, 64'h7FF8000000000005);
    drive(64'h7FF0000000000005, 1'b1, 1'b0);
    chk("R7 pulse off", {63'h0, invalidPulse}, 64'h0);
    chk("R8 no quiet passthrough", result, 64'h7FF0000000000005);

    // R7: back-to-back quiets, legacy then 2008
    drive(64'hFFF8000000000000, 1'b0, 1'b1);
    chk("R5 zero-fraction fix", result, 64'hFFF4000000000000);
    drive(64'h7FF0000000000002, 1'b1, 1'b1);
    chk("R7 back-to-back pulse", {63'h0, invalidPulse}, 64'h1);
    chk("R4 second quiet", result, 64'h7FF8000000000002);
    drive(64'h0, 1'b0, 1'b0);
    chk("R7 pulse ends", {63'h0, invalidPulse}, 64'h0);

    // R3: same pattern flips meaning with the mode bit
    drive(64'h7FFC000000000000, 1'b0, 1'b0);
    chk("R3 legacy signaling", {63'h0, isSignaling}, 64'h1);
    drive(64'h7FFC000000000000, 1'b1, 1'b0);
    chk("R3 2008 quiet", {63'h0, isSignaling}, 64'h0);

    // R9: reset mid-run
    rstN = 1'b0;
    drive(64'h7FF0000000000001, 1'b1, 1'b0);
    chk("R9 reset again", {result[58:0], classOut}, 64'h1);
    rstN = 1'b1;
    drive(64'h0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule